// File: doc/BRIEF.md
# DRAM Column Burst Buffer

This block stages one 128-bit column group between a row register of 8,192 bits and an 8-bit data port. A 10-bit column address selects the group and the starting segment. On a read, the selected group is copied into the staging buffer in one cycle. A burst counter then sends it out one byte per cycle. On a write, bytes arriving on the data port fill the staging buffer under the same counter. When the last beat has been taken, the received segments are written back into the selected group in a single cycle.

A command asks for either a full 16-beat burst or a chopped 8-beat burst. A stop request raised during a running burst cuts it short. While a burst or its write-back is in progress, the block reports busy and ignores new commands. All widths and counts are parameters. The defaults are 8-bit segments, 16 beats and 64 groups.

Top module: `col_burst_buffer`

## Requirements
- R1: After reset, busy, rd_valid and wr_strobe are low and every bit of the row register reads back as zero.
- R2: col_addr[9:4] selects the group and col_addr[3:0] gives the starting segment. Group g covers row bits [128g+127:128g], and segment k of a group covers bits [8k+7:8k] of that group.
- R3: A read accepted at a clock edge loads the whole group into the buffer at that edge. Beat i appears on rd_data in the cycle after i more edges and carries segment (start+i) mod 16.
- R4: A full read or write burst raises its strobe (rd_valid or wr_strobe) for exactly 16 consecutive cycles.
- R5: When cmd_chop is high at acceptance, the burst lasts exactly 8 beats and keeps the same ascending, wrapping segment order.
- R6: During a write, the byte on wr_data is captured at each edge where wr_strobe is high, into segment (start+i) mod 16. All captured segments are written into the group in the single cycle after the last beat.
- R7: A write commits only the segments that were received. The other segments of the group keep their old contents.
- R8: If stop_req is high during beat n, the burst ends after beat max(n,7), but never later than its own length.
- R9: busy is high from the acceptance edge until the last read beat, or until the write-back cycle has finished. A command presented while busy is ignored and has no effect on the data port or on the row.
- R10: A write to one group leaves every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, accepted when not busy |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_chop | input | 1 | 1 = 8-beat chopped burst |
| col_addr | input | 10 | Group select (upper 6 bits) and start segment (lower 4 bits) |
| stop_req | input | 1 | Ends the running burst early |
| wr_data | input | 8 | Write byte, captured while wr_strobe is high |
| busy | output | 1 | Burst or write-back in progress |
| rd_valid | output | 1 | rd_data carries a read beat |
| rd_data | output | 8 | Read byte |
| wr_strobe | output | 1 | wr_data is captured at the coming edge |

## Verification
The first read byte is due one edge after the acceptance edge, and every further byte one edge later. A write byte must be present before each edge at which wr_strobe is high. The write-back takes effect one edge after the last write beat, so busy is still high at the sample point that follows the last strobe and low one cycle later. The bench drives every input and samples every output on the falling edge, so each check falls midway between the edges that produce its value. Read bytes are checked in order against a queue filled from a shadow row, and each burst's beat count is compared with the length that R4, R5 and R8 give.

// File: rtl/cbb_pkg.sv
package cbb_pkg;

    localparam int SEG_W_DEF  = 8;
    localparam int BEATS_DEF  = 16;
    localparam int GROUPS_DEF = 64;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_COMMIT = 2'd3
    } burst_state_e;

    // Limit of the final beat index once a stop request is seen during beat beat_no.
    function automatic int unsigned trim_limit(int unsigned beat_no,
                                               int unsigned cur_lim,
                                               int unsigned floor_lim);
        int unsigned cand;
        cand = (beat_no > floor_lim) ? beat_no : floor_lim;
        return (cand < cur_lim) ? cand : cur_lim;
    endfunction

endpackage

// File: rtl/cbb_row_array.sv
module cbb_row_array
    import cbb_pkg::*;
#(
    parameter int SEG_W  = SEG_W_DEF,
    parameter int BEATS  = BEATS_DEF,
    parameter int GROUPS = GROUPS_DEF,
    localparam int BUF_W = SEG_W * BEATS,
    localparam int GRP_W = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GRP_W-1:0] rd_grp,
    output logic [BUF_W-1:0] rd_word,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [BUF_W-1:0] wr_word,
    input  logic [BEATS-1:0] wr_mask
);

    logic [BUF_W-1:0] row_q [GROUPS];

    assign rd_word = row_q[rd_grp];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < GROUPS; g++) begin
                row_q[g] <= '0;
            end
        end else if (wr_en) begin
            for (int s = 0; s < BEATS; s++) begin
                if (wr_mask[s]) begin
                    row_q[wr_grp][s*SEG_W +: SEG_W] <= wr_word[s*SEG_W +: SEG_W];
                end
            end
        end
    end

    // R6: a fully masked write-back lands in the addressed group on the next cycle
    p_commit_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (&wr_mask)) |=> (row_q[$past(wr_grp)] == $past(wr_word)));

    // R7: a segment left out of the mask keeps its value
    p_unmasked_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_mask[0]) |=> (row_q[$past(wr_grp)][SEG_W-1:0]
                                    == $past(row_q[wr_grp][SEG_W-1:0])));

endmodule

// File: rtl/cbb_stage_buf.sv
module cbb_stage_buf
    import cbb_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF,
    parameter int BEATS = BEATS_DEF,
    localparam int BUF_W = SEG_W * BEATS,
    localparam int POS_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [BUF_W-1:0] load_word,
    input  logic             clear_en,
    input  logic             seg_we,
    input  logic [POS_W-1:0] seg_idx,
    input  logic [SEG_W-1:0] seg_in,
    output logic [SEG_W-1:0] seg_out,
    output logic [BUF_W-1:0] word_out,
    output logic [BEATS-1:0] mask_out
);

    logic [SEG_W-1:0] seg_q  [BEATS];
    logic [BEATS-1:0] mask_q;

    for (genvar k = 0; k < BEATS; k++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                seg_q[k]  <= '0;
                mask_q[k] <= 1'b0;
            end else if (load_en) begin
                seg_q[k]  <= load_word[k*SEG_W +: SEG_W];
                mask_q[k] <= 1'b0;
            end else if (clear_en) begin
                mask_q[k] <= 1'b0;
            end else if (seg_we && (seg_idx == POS_W'(k))) begin
                seg_q[k]  <= seg_in;
                mask_q[k] <= 1'b1;
            end
        end
        assign word_out[k*SEG_W +: SEG_W] = seg_q[k];
    end

    assign seg_out  = seg_q[seg_idx];
    assign mask_out = mask_q;

    // R6: each captured beat marks exactly one more segment as received
    p_one_seg_per_beat_r6: assert property (@(posedge clk) disable iff (rst)
        (seg_we && !load_en && !clear_en && !mask_q[seg_idx])
            |=> ($countones(mask_q) == $countones($past(mask_q)) + 1));

endmodule

// File: rtl/cbb_burst_ctrl.sv
module cbb_burst_ctrl
    import cbb_pkg::*;
#(
    parameter int BEATS  = BEATS_DEF,
    parameter int GROUPS = GROUPS_DEF,
    localparam int POS_W = $clog2(BEATS),
    localparam int GRP_W = $clog2(GROUPS),
    localparam int CHOP  = BEATS / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic             cmd_chop,
    input  logic [GRP_W-1:0] cmd_grp,
    input  logic [POS_W-1:0] cmd_start,
    input  logic             stop_req,
    output logic             busy,
    output logic             rd_valid,
    output logic             wr_strobe,
    output logic             load_en,
    output logic             clear_en,
    output logic [POS_W-1:0] seg_idx,
    output logic             commit_en,
    output logic [GRP_W-1:0] grp_out
);

    localparam logic [POS_W-1:0] CHOP_M1 = POS_W'(CHOP - 1);
    localparam logic [POS_W-1:0] FULL_M1 = POS_W'(BEATS - 1);

    burst_state_e     state_q;
    logic [POS_W-1:0] cnt_q;
    logic [POS_W-1:0] beat_q;
    logic [POS_W-1:0] lim_q;
    logic [GRP_W-1:0] grp_q;

    logic             accept;
    logic             in_beat;
    logic [POS_W-1:0] eff_lim;
    logic             last_beat;

    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign in_beat   = (state_q == ST_READ) || (state_q == ST_WRITE);

    always_comb begin
        eff_lim = lim_q;
        if (stop_req && in_beat) begin
            eff_lim = POS_W'(trim_limit(int'(beat_q), int'(lim_q), int'(CHOP_M1)));
        end
    end

    assign last_beat = in_beat && (beat_q == eff_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            beat_q  <= '0;
            lim_q   <= '0;
            grp_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= cmd_write ? ST_WRITE : ST_READ;
                        cnt_q   <= cmd_start;
                        beat_q  <= '0;
                        lim_q   <= cmd_chop ? CHOP_M1 : FULL_M1;
                        grp_q   <= cmd_grp;
                    end
                end
                ST_READ, ST_WRITE: begin
                    cnt_q  <= cnt_q + 1'b1;
                    beat_q <= beat_q + 1'b1;
                    lim_q  <= eff_lim;
                    if (last_beat) begin
                        state_q <= (state_q == ST_WRITE) ? ST_COMMIT : ST_IDLE;
                    end
                end
                ST_COMMIT: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign rd_valid  = (state_q == ST_READ);
    assign wr_strobe = (state_q == ST_WRITE);
    assign load_en   = accept && !cmd_write;
    assign clear_en  = accept && cmd_write;
    assign seg_idx   = cnt_q;
    assign commit_en = (state_q == ST_COMMIT);
    assign grp_out   = grp_q;

    // R9: a command seen while busy leaves the captured group untouched
    p_busy_blocks_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> (grp_q == $past(grp_q)));

    // R3: the segment pointer advances by one on every consecutive beat
    p_cnt_steps_r3: assert property (@(posedge clk) disable iff (rst)
        (in_beat && $past(in_beat) && (state_q == $past(state_q)))
            |-> (cnt_q == POS_W'($past(cnt_q) + 1'b1)));

    // R4: the beat number never passes the burst limit
    p_len_bound_r4: assert property (@(posedge clk) disable iff (rst)
        in_beat |-> (beat_q <= lim_q));

    // R6: the write-back cycle only follows write beats
    p_commit_after_write_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT) |-> ($past(state_q) == ST_WRITE));

    // R8: a stop never ends a burst before the half-length beat
    p_stop_floor_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(in_beat) && !in_beat) |-> ($past(beat_q) >= CHOP_M1));

endmodule

// File: rtl/col_burst_buffer.sv
module col_burst_buffer
    import cbb_pkg::*;
#(
    parameter int SEG_W  = SEG_W_DEF,
    parameter int BEATS  = BEATS_DEF,
    parameter int GROUPS = GROUPS_DEF,
    localparam int POS_W = $clog2(BEATS),
    localparam int GRP_W = $clog2(GROUPS),
    localparam int COL_W = GRP_W + POS_W,
    localparam int BUF_W = SEG_W * BEATS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic             cmd_chop,
    input  logic [COL_W-1:0] col_addr,
    input  logic             stop_req,
    input  logic [SEG_W-1:0] wr_data,
    output logic             busy,
    output logic             rd_valid,
    output logic [SEG_W-1:0] rd_data,
    output logic             wr_strobe
);

    logic [GRP_W-1:0] cmd_grp;
    logic [POS_W-1:0] cmd_start;
    logic             load_en;
    logic             clear_en;
    logic [POS_W-1:0] seg_idx;
    logic             commit_en;
    logic [GRP_W-1:0] grp_q;
    logic [BUF_W-1:0] row_word;
    logic [BUF_W-1:0] stage_word;
    logic [BEATS-1:0] stage_mask;
    logic [SEG_W-1:0] stage_seg;

    assign cmd_grp   = col_addr[COL_W-1:POS_W];
    assign cmd_start = col_addr[POS_W-1:0];

    cbb_burst_ctrl #(.BEATS(BEATS), .GROUPS(GROUPS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_chop  (cmd_chop),
        .cmd_grp   (cmd_grp),
        .cmd_start (cmd_start),
        .stop_req  (stop_req),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .wr_strobe (wr_strobe),
        .load_en   (load_en),
        .clear_en  (clear_en),
        .seg_idx   (seg_idx),
        .commit_en (commit_en),
        .grp_out   (grp_q)
    );

    cbb_stage_buf #(.SEG_W(SEG_W), .BEATS(BEATS)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_word (row_word),
        .clear_en  (clear_en),
        .seg_we    (wr_strobe),
        .seg_idx   (seg_idx),
        .seg_in    (wr_data),
        .seg_out   (stage_seg),
        .word_out  (stage_word),
        .mask_out  (stage_mask)
    );

    cbb_row_array #(.SEG_W(SEG_W), .BEATS(BEATS), .GROUPS(GROUPS)) u_row (
        .clk     (clk),
        .rst     (rst),
        .rd_grp  (cmd_grp),
        .rd_word (row_word),
        .wr_en   (commit_en),
        .wr_grp  (grp_q),
        .wr_word (stage_word),
        .wr_mask (stage_mask)
    );

    assign rd_data = rd_valid ? stage_seg : '0;

    // R9: read beats only appear while the block reports busy
    p_rd_inside_busy_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

    // R6: a write-back always carries at least half a burst of segments
    p_commit_has_data_r6: assert property (@(posedge clk) disable iff (rst)
        commit_en |-> ($countones(stage_mask) >= BEATS / 2));

endmodule

// File: tb/col_burst_buffer_test.sv
module col_burst_buffer_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, cmd_write, cmd_chop, stop_req;
    logic [9:0] col_addr;
    logic [7:0] wr_data;
    logic       busy, rd_valid, wr_strobe;
    logic [7:0] rd_data;

    always #2 clk = ~clk;

    col_burst_buffer uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_chop(cmd_chop), .col_addr(col_addr), .stop_req(stop_req),
        .wr_data(wr_data), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .wr_strobe(wr_strobe)
    );

    logic [127:0] model [64];
    logic [7:0]   exp_q [$];
    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read bytes as beats appear (R3, R4)
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 extra read beat", int'(rd_data), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                check(rd_data === e, "R3 read byte", int'(rd_data), int'(e));
            end
        end
    end

    function automatic int burst_len(input bit chop, input int stop_at);
        int l = chop ? 8 : 16;
        if (stop_at >= 0 && stop_at < l) begin
            int s = (stop_at < 7) ? 8 : stop_at + 1;
            if (s < l) l = s;
        end
        return l;
    endfunction

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 64) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic do_read(input int grp, input int start, input bit chop,
                           input int stop_at, input int intrude_grp, input string req);
        int l = burst_len(chop, stop_at);
        int n = 0;
        int wr_seen = 0;
        for (int i = 0; i < l; i++) begin
            exp_q.push_back(model[grp][((start + i) % 16) * 8 +: 8]);
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_chop = chop;
        col_addr  = {grp[5:0], start[3:0]};
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy === 1'b1, "R9 busy after read accept", int'(busy), 1);
        while (rd_valid) begin
            stop_req = (n == stop_at);
            if (intrude_grp >= 0 && n == 3) begin
                cmd_valid = 1'b1; cmd_write = 1'b1; cmd_chop = 1'b0;
                col_addr  = {intrude_grp[5:0], 4'd0};
            end else begin
                cmd_valid = 1'b0;
            end
            if (wr_strobe) wr_seen++;
            n++;
            @(negedge clk);
        end
        stop_req = 1'b0; cmd_valid = 1'b0;
        check(n == l, req, n, l);
        check(wr_seen == 0 && wr_strobe === 1'b0, "R9 no write strobe from ignored cmd",
              wr_seen, 0);
        wait_idle();
    endtask

    task automatic do_write(input int grp, input int start, input bit chop,
                            input int stop_at, input int salt, input string req);
        int l = burst_len(chop, stop_at);
        int n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_chop = chop;
        col_addr  = {grp[5:0], start[3:0]};
        @(negedge clk);
        cmd_valid = 1'b0;
        while (wr_strobe) begin
            automatic logic [7:0] b = 8'(grp * 7 + n * 13 + salt);
            wr_data  = b;
            stop_req = (n == stop_at);
            model[grp][((start + n) % 16) * 8 +: 8] = b;
            n++;
            @(negedge clk);
        end
        stop_req = 1'b0;
        check(n == l, req, n, l);
        check(busy === 1'b1, "R9 busy during write-back", int'(busy), 1);
        @(negedge clk);
        check(busy === 1'b0, "R9 idle after write-back", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int g = 0; g < 64; g++) model[g] = '0;
        rst = 1'b1; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_chop = 1'b0;
        stop_req = 1'b0; col_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        check(rd_valid === 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
        check(wr_strobe === 1'b0, "R1 wr_strobe after reset", int'(wr_strobe), 0);
        do_read(5, 0, 1'b0, -1, -1, "R1 R4 zero row full read length");

        // R6, R3, R4: full write then reads in several orders
        do_write(10, 0, 1'b0, -1, 1, "R4 R6 full write length");
        do_read(10, 0, 1'b0, -1, -1, "R3 R4 full read length");
        do_read(10, 5, 1'b0, -1, -1, "R2 R3 wrapped start length");
        do_read(10, 12, 1'b1, -1, -1, "R5 chopped read length");

        // R10: neighbour groups untouched
        do_read(9, 0, 1'b0, -1, -1, "R10 lower neighbour length");
        do_read(11, 0, 1'b0, -1, -1, "R10 upper neighbour length");

        // R7: chopped writes commit only received segments
        do_write(11, 4, 1'b1, -1, 2, "R5 R7 chopped write length");
        do_read(11, 0, 1'b0, -1, -1, "R7 half-filled group length");
        do_write(10, 8, 1'b1, -1, 3, "R7 chopped overwrite length");
        do_read(10, 3, 1'b0, -1, -1, "R7 merged group length");

        // R8: stop requests
        do_read(10, 0, 1'b0, 2, -1, "R8 early stop gives 8 beats");
        do_read(10, 6, 1'b0, 11, -1, "R8 late stop ends after beat 11");
        do_read(10, 0, 1'b1, 9, -1, "R8 stop past chop length");
        do_write(20, 14, 1'b0, 3, 4, "R8 R7 stopped write length");
        do_read(20, 0, 1'b0, -1, -1, "R7 R8 stopped write readback length");

        // R9: write command during a read is ignored
        do_read(10, 0, 1'b0, -1, 30, "R9 read with intruding cmd length");
        do_read(30, 0, 1'b0, -1, -1, "R9 intruded group still zero length");

        // R2, R10: top group boundary
        do_write(63, 15, 1'b0, -1, 5, "R2 last group write length");
        do_read(63, 0, 1'b0, -1, -1, "R2 last group read length");
        do_read(62, 0, 1'b0, -1, -1, "R10 below last group length");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 missing read beats", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule